// File: doc/BRIEF.md
# UART Interrupt Identification and FIFO Control

This block is the interrupt arbitration and FIFO-control slice of a 16550-style UART register file. It watches the register bus at base-relative offsets and the status flags of the surrounding UART: receive and transmit FIFO fill counts, a receive idle-timeout event, the transmit-holding-empty flag and the modem-line change flags. It keeps one pending latch per interrupt source. Each latch has its own set and clear rules. The block reports the most urgent enabled source as a 4-bit code and drives a single interrupt line.

Offset 2 is shared. A read there returns the identification byte. A write there updates the FIFO control register, which holds the FIFO-mode enable and issues self-clearing flush pulses to the receive and transmit FIFOs. The FIFOs, shifters, baud generator, timeout counter and the interrupt-enable register live outside the block; their results arrive as inputs.

Top module: `uart_iir_fcr`

## Requirements
- R1: A synchronous active-high reset clears FIFO mode, both flush pulses, every pending source and the interrupt line, so the offset-2 byte reads 0x01.
- R2: A write at offset 2 stores data bit 0 as the FIFO-mode flag, effective from the next cycle. The offset-2 read byte carries that flag in bits 7 and 6, zeros in bits 5:4, and the source code in bits 3:0.
- R3: A write at offset 2 with data bit 1 set raises rx_fifo_rst for exactly the next cycle; data bit 2 does the same for tx_fifo_rst. Zeros in those bits, with bit 0 unchanged, produce no pulse.
- R4: A write at offset 2 that changes the FIFO-mode flag pulses both rx_fifo_rst and tx_fifo_rst in the next cycle. Rewriting the same mode value with bits 1 and 2 clear pulses neither.
- R5: The source codes are 0b1100 for receive timeout, 0b0010 for transmit request and 0b0000 for modem change, ranked in that order. With nothing enabled and pending the code is 0b0001. Only the top-ranked source is reported, and a lower one appears once the higher ones clear.
- R6: A receive-timeout source becomes pending only in FIFO mode, with a nonzero receive count and the timeout event present. It is cleared by a read at offset 0 or by any write that flushes the receive FIFO.
- R7: The transmit condition is thr_empty in non-FIFO mode and tx_count <= TX_DEPTH/2 in FIFO mode. The source becomes pending only on a 0-to-1 change of that condition, and it is dropped when the condition goes false.
- R8: A transmit request is cleared by a write at offset 0, or by a read at offset 2 while it is the reported code. A read at offset 2 while a higher source is reported leaves it pending.
- R9: Any set bit of msr_delta makes the modem source pending. A read at offset 6 clears it unless a new change arrives in the same cycle.
- R10: src_en bit 0 enables modem, bit 1 transmit request and bit 2 receive timeout. A disabled source keeps its pending state but is neither reported nor drives irq, and irq is high exactly when some enabled source is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Base-relative register offset |
| bus_wr | input | 1 | Register write strobe, one cycle per access |
| bus_rd | input | 1 | Register read strobe, one cycle per access |
| bus_wdata | input | DATA_W | Write data |
| iir_rdata | output | DATA_W | Identification byte for offset-2 reads |
| rx_count | input | RXC_W | Receive FIFO fill level |
| tx_count | input | TXC_W | Transmit FIFO fill level |
| rx_timeout | input | 1 | Receive idle-timeout event |
| thr_empty | input | 1 | Transmit holding register empty |
| msr_delta | input | 4 | Modem line change flags (CTS, DSR, RI, DCD) |
| src_en | input | 3 | Per-source interrupt enables |
| irq | output | 1 | Interrupt request |
| fifo_en | output | 1 | FIFO mode enable |
| rx_fifo_rst | output | 1 | One-cycle receive FIFO flush |
| tx_fifo_rst | output | 1 | One-cycle transmit FIFO flush |

## Verification
The bench builds the block with its defaults: a 3-bit offset and 16-entry FIFOs with 5-bit counts. With those values the transmit threshold is 8, so fill levels 8 and 9 sit on either side of it and the bench can toggle the FIFO-mode transmit condition with a single count change. The same build also reaches the non-FIFO empty-flag condition, mode changes in both directions, and the per-source enables alongside every priority overlap.

// File: rtl/uart_iir_pkg.sv
package uart_iir_pkg;

    // register offsets relative to the UART base
    localparam int unsigned OFF_DATA = 0;
    localparam int unsigned OFF_IDFC = 2;
    localparam int unsigned OFF_MSTS = 6;

    // control byte bit positions
    localparam int unsigned FC_MODE  = 0;
    localparam int unsigned FC_RXCLR = 1;
    localparam int unsigned FC_TXCLR = 2;

    typedef enum logic [3:0] {
        ID_MODEM = 4'b0000,
        ID_NONE  = 4'b0001,
        ID_TXREQ = 4'b0010,
        ID_RXTMO = 4'b1100
    } irq_id_e;

    // one bit per source, bit 0 = modem, bit 1 = transmit, bit 2 = timeout
    typedef struct packed {
        logic rx_tmo;
        logic tx_req;
        logic modem;
    } src_vec_t;

    typedef struct packed {
        logic data_wr;
        logic data_rd;
        logic fc_wr;
        logic id_rd;
        logic ms_rd;
    } bus_hit_t;

    function automatic logic [7:0] id_byte(input logic fen, input irq_id_e id);
        return {fen, fen, 2'b00, id};
    endfunction

endpackage

// File: rtl/uart_bus_decode.sv
module uart_bus_decode
    import uart_iir_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    output bus_hit_t          hit
);
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFF_DATA);
    localparam logic [ADDR_W-1:0] A_IDFC = ADDR_W'(OFF_IDFC);
    localparam logic [ADDR_W-1:0] A_MSTS = ADDR_W'(OFF_MSTS);

    logic at_data, at_idfc, at_msts;

    always_comb begin
        at_data = (addr == A_DATA);
        at_idfc = (addr == A_IDFC);
        at_msts = (addr == A_MSTS);
        hit.data_wr = wr & at_data;
        hit.data_rd = rd & at_data;
        hit.fc_wr   = wr & at_idfc;
        hit.id_rd   = rd & at_idfc;
        hit.ms_rd   = rd & at_msts;
    end

endmodule

// File: rtl/uart_fcr_ctl.sv
module uart_fcr_ctl
    import uart_iir_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fc_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              fifo_en,
    output logic              rx_flush,
    output logic              tx_flush,
    output logic              rx_pulse,
    output logic              tx_pulse
);
    logic mode_q;
    logic mode_flip;
    logic [1:0] flush_now;
    logic [1:0] flush_q;

    assign mode_flip = fc_wr && (wdata[FC_MODE] != mode_q);

    // index 0 = receive, index 1 = transmit
    localparam int unsigned CLR_BIT [2] = '{FC_RXCLR, FC_TXCLR};

    for (genvar g = 0; g < 2; g++) begin : g_flush
        assign flush_now[g] = (fc_wr && wdata[CLR_BIT[g]]) || mode_flip;

        always_ff @(posedge clk) begin
            if (rst) flush_q[g] <= 1'b0;
            else     flush_q[g] <= flush_now[g];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        mode_q <= 1'b0;
        else if (fc_wr) mode_q <= wdata[FC_MODE];
    end

    assign fifo_en  = mode_q;
    assign rx_flush = flush_now[0];
    assign tx_flush = flush_now[1];
    assign rx_pulse = flush_q[0];
    assign tx_pulse = flush_q[1];

    // R3: a flush pulse always follows a control write
    a_r3_pulse_after_write: assert property (@(posedge clk) disable iff (rst)
        (rx_pulse || tx_pulse) |-> $past(fc_wr));

    // R2: the mode flag moves only on a control write
    a_r2_mode_holds: assert property (@(posedge clk) disable iff (rst)
        !fc_wr |=> $stable(fifo_en));

    // R4: a mode change flushes both sides
    a_r4_flip_flushes_both: assert property (@(posedge clk) disable iff (rst)
        (fc_wr && (wdata[FC_MODE] != fifo_en)) |=> (rx_pulse && tx_pulse));

endmodule

// File: rtl/uart_irq_src.sv
module uart_irq_src
    import uart_iir_pkg::*;
#(
    parameter int RXC_W     = 5,
    parameter int TXC_W     = 5,
    parameter int TX_THRESH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fifo_en,
    input  bus_hit_t         hit,
    input  logic             rx_flush,
    input  logic [RXC_W-1:0] rx_count,
    input  logic [TXC_W-1:0] tx_count,
    input  logic             rx_timeout,
    input  logic             thr_empty,
    input  logic [3:0]       msr_delta,
    input  logic             tx_reported,
    output src_vec_t         pend
);
    localparam logic [TXC_W-1:0] THRESH = TXC_W'(TX_THRESH);
    localparam int NSRC = $bits(src_vec_t);

    logic     tx_cond;
    logic     cond_q;
    src_vec_t set_v;
    src_vec_t clr_v;
    logic [NSRC-1:0] pend_q;

    always_comb begin
        tx_cond = fifo_en ? (tx_count <= THRESH) : thr_empty;

        set_v.rx_tmo = fifo_en && rx_timeout && (rx_count != '0);
        clr_v.rx_tmo = hit.data_rd || rx_flush;

        set_v.tx_req = tx_cond && !cond_q;
        clr_v.tx_req = hit.data_wr || (hit.id_rd && tx_reported) || !tx_cond;

        set_v.modem  = |msr_delta;
        clr_v.modem  = hit.ms_rd && !set_v.modem;
    end

    always_ff @(posedge clk) begin
        if (rst) cond_q <= 1'b0;
        else     cond_q <= tx_cond;
    end

    // one latch per source; clear wins over set
    for (genvar s = 0; s < NSRC; s++) begin : g_latch
        always_ff @(posedge clk) begin
            if (rst)
                pend_q[s] <= 1'b0;
            else
                pend_q[s] <= (pend_q[s] || set_v[s]) && !clr_v[s];
        end
    end

    assign pend = src_vec_t'(pend_q);

    // R6: timeout never survives outside FIFO mode
    a_r6_tmo_needs_fifo: assert property (@(posedge clk) disable iff (rst)
        pend.rx_tmo |-> fifo_en);

    // R8: transmit data write clears the request
    a_r8_data_wr_clears: assert property (@(posedge clk) disable iff (rst)
        hit.data_wr |=> !pend.tx_req);

    // R9: status read without a new change clears the modem source
    a_r9_msr_read_clears: assert property (@(posedge clk) disable iff (rst)
        (hit.ms_rd && (msr_delta == 4'b0000)) |=> !pend.modem);

    // R7: a request never appears without its condition
    a_r7_req_needs_cond: assert property (@(posedge clk) disable iff (rst)
        $rose(pend.tx_req) |-> $past(tx_cond));

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_iir_pkg::*;
(
    input  src_vec_t pend,
    input  src_vec_t en,
    output irq_id_e  id,
    output src_vec_t grant,
    output logic     irq
);
    src_vec_t live;

    always_comb begin
        live  = pend & en;
        grant = '0;
        id    = ID_NONE;
        if (live.rx_tmo) begin
            grant.rx_tmo = 1'b1;
            id           = ID_RXTMO;
        end else if (live.tx_req) begin
            grant.tx_req = 1'b1;
            id           = ID_TXREQ;
        end else if (live.modem) begin
            grant.modem  = 1'b1;
            id           = ID_MODEM;
        end
        irq = |live;
    end

endmodule

// File: rtl/uart_iir_fcr.sv
module uart_iir_fcr
    import uart_iir_pkg::*;
#(
    parameter  int ADDR_W   = 3,
    parameter  int DATA_W   = 8,
    parameter  int RX_DEPTH = 16,
    parameter  int TX_DEPTH = 16,
    localparam int RXC_W    = $clog2(RX_DEPTH) + 1,
    localparam int TXC_W    = $clog2(TX_DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] iir_rdata,
    input  logic [RXC_W-1:0]  rx_count,
    input  logic [TXC_W-1:0]  tx_count,
    input  logic              rx_timeout,
    input  logic              thr_empty,
    input  logic [3:0]        msr_delta,
    input  logic [2:0]        src_en,
    output logic              irq,
    output logic              fifo_en,
    output logic              rx_fifo_rst,
    output logic              tx_fifo_rst
);
    localparam int TX_HALF = TX_DEPTH / 2;

    bus_hit_t hit;
    logic     rx_flush, tx_flush;
    src_vec_t pend, grant, en_v;
    irq_id_e  id;

    assign en_v = src_vec_t'(src_en);

    uart_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
        .wr   (bus_wr),
        .rd   (bus_rd),
        .addr (bus_addr),
        .hit  (hit)
    );

    uart_fcr_ctl #(.DATA_W(DATA_W)) u_fcr (
        .clk      (clk),
        .rst      (rst),
        .fc_wr    (hit.fc_wr),
        .wdata    (bus_wdata),
        .fifo_en  (fifo_en),
        .rx_flush (rx_flush),
        .tx_flush (tx_flush),
        .rx_pulse (rx_fifo_rst),
        .tx_pulse (tx_fifo_rst)
    );

    uart_irq_src #(
        .RXC_W     (RXC_W),
        .TXC_W     (TXC_W),
        .TX_THRESH (TX_HALF)
    ) u_src (
        .clk         (clk),
        .rst         (rst),
        .fifo_en     (fifo_en),
        .hit         (hit),
        .rx_flush    (rx_flush),
        .rx_count    (rx_count),
        .tx_count    (tx_count),
        .rx_timeout  (rx_timeout),
        .thr_empty   (thr_empty),
        .msr_delta   (msr_delta),
        .tx_reported (grant.tx_req),
        .pend        (pend)
    );

    uart_irq_prio u_prio (
        .pend  (pend),
        .en    (en_v),
        .id    (id),
        .grant (grant),
        .irq   (irq)
    );

    assign iir_rdata = DATA_W'(id_byte(fifo_en, id));

    // R5: at most one source granted at a time
    a_r5_single_grant: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    // R5: an enabled timeout always wins
    a_r5_timeout_wins: assert property (@(posedge clk) disable iff (rst)
        (pend.rx_tmo && src_en[2]) |-> (iir_rdata[3:0] == 4'b1100));

    // R10: irq and the reported code agree
    a_r10_irq_matches_code: assert property (@(posedge clk) disable iff (rst)
        irq == (iir_rdata[3:0] != 4'b0001));

    // R3: the flush strobes are not raised while in reset
    a_r3_quiet_after_reset: assert property (@(posedge clk)
        $past(rst) |-> !(rx_fifo_rst || tx_fifo_rst));

endmodule

// File: tb/tb_uart_iir_fcr.sv
module tb_uart_iir_fcr;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] iir_rdata;
    logic [4:0] rx_count = '0, tx_count = 5'd16;
    logic       rx_timeout = 1'b0, thr_empty = 1'b0;
    logic [3:0] msr_delta = '0;
    logic [2:0] src_en = 3'b111;
    logic       irq, fifo_en, rx_fifo_rst, tx_fifo_rst;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    uart_iir_fcr dut (
        .clk, .rst, .bus_addr, .bus_wr, .bus_rd, .bus_wdata, .iir_rdata,
        .rx_count, .tx_count, .rx_timeout, .thr_empty, .msr_delta, .src_en,
        .irq, .fifo_en, .rx_fifo_rst, .tx_fifo_rst
    );

    typedef struct packed {
        logic [1:0] op;     // 0 idle, 1 write, 2 read
        logic [2:0] addr;
        logic [7:0] wd;
        logic [4:0] rxc;
        logic [4:0] txc;
        logic       to;
        logic       thre;
        logic [3:0] msr;
        logic       e_irq;
        logic [7:0] e_id;
        logic       e_fen;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VEC [NV] = '{
        '{2'd0,3'd0,8'h00,5'd0,5'd16,1'b0,1'b1,4'h0,1'b1,8'h02,1'b0,4'd7}, // R7 empty rises
        '{2'd2,3'd2,8'h00,5'd0,5'd16,1'b0,1'b1,4'h0,1'b0,8'h01,1'b0,4'd8}, // R8 id read clears
        '{2'd0,3'd0,8'h00,5'd0,5'd16,1'b0,1'b1,4'h0,1'b0,8'h01,1'b0,4'd7}, // R7 no re-arm
        '{2'd0,3'd0,8'h00,5'd0,5'd16,1'b0,1'b0,4'h0,1'b0,8'h01,1'b0,4'd7}, // R7 falls
        '{2'd0,3'd0,8'h00,5'd0,5'd16,1'b0,1'b1,4'h0,1'b1,8'h02,1'b0,4'd7}, // R7 rises again
        '{2'd1,3'd0,8'h55,5'd0,5'd16,1'b0,1'b1,4'h0,1'b0,8'h01,1'b0,4'd8}, // R8 data write clears
        '{2'd0,3'd0,8'h00,5'd0,5'd16,1'b0,1'b1,4'h2,1'b1,8'h00,1'b0,4'd9}, // R9 modem change
        '{2'd0,3'd0,8'h00,5'd0,5'd16,1'b0,1'b0,4'h0,1'b1,8'h00,1'b0,4'd5}, // R5 modem alone
        '{2'd0,3'd0,8'h00,5'd0,5'd16,1'b0,1'b1,4'h0,1'b1,8'h02,1'b0,4'd5}, // R5 tx over modem
        '{2'd2,3'd2,8'h00,5'd0,5'd16,1'b0,1'b1,4'h0,1'b1,8'h00,1'b0,4'd8}, // R8 then modem shows
        '{2'd2,3'd6,8'h00,5'd0,5'd16,1'b0,1'b0,4'h0,1'b0,8'h01,1'b0,4'd9}, // R9 status read
        '{2'd1,3'd2,8'h01,5'd0,5'd16,1'b0,1'b0,4'h0,1'b0,8'hC1,1'b1,4'd2}, // R2 fifo on
        '{2'd0,3'd0,8'h00,5'd0,5'd8, 1'b0,1'b0,4'h0,1'b1,8'hC2,1'b1,4'd7}, // R7 half threshold
        '{2'd0,3'd0,8'h00,5'd3,5'd8, 1'b1,1'b0,4'h0,1'b1,8'hCC,1'b1,4'd6}, // R6 timeout
        '{2'd2,3'd2,8'h00,5'd3,5'd8, 1'b0,1'b0,4'h0,1'b1,8'hCC,1'b1,4'd8}, // R8 not reported
        '{2'd2,3'd0,8'h00,5'd3,5'd8, 1'b0,1'b0,4'h0,1'b1,8'hC2,1'b1,4'd6}, // R6 rx read clears
        '{2'd0,3'd0,8'h00,5'd3,5'd8, 1'b1,1'b0,4'h0,1'b1,8'hCC,1'b1,4'd6}, // R6 set again
        '{2'd1,3'd2,8'h03,5'd3,5'd8, 1'b0,1'b0,4'h0,1'b1,8'hC2,1'b1,4'd6}, // R6 flush clears
        '{2'd0,3'd0,8'h00,5'd0,5'd9, 1'b0,1'b0,4'h0,1'b0,8'hC1,1'b1,4'd7}, // R7 above half drops
        '{2'd0,3'd0,8'h00,5'd0,5'd8, 1'b1,1'b0,4'h0,1'b1,8'hC2,1'b1,4'd6}, // R6 empty rx ignored
        '{2'd1,3'd0,8'h00,5'd0,5'd8, 1'b0,1'b0,4'h0,1'b0,8'hC1,1'b1,4'd8}, // R8 data write
        '{2'd1,3'd2,8'h00,5'd0,5'd8, 1'b0,1'b1,4'h0,1'b0,8'h01,1'b0,4'd2}, // R2 fifo off
        '{2'd0,3'd0,8'h00,5'd3,5'd8, 1'b1,1'b1,4'h0,1'b0,8'h01,1'b0,4'd6}  // R6 non-fifo ignored
    };

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic put(input logic [1:0] op, input logic [2:0] a, input logic [7:0] d);
        bus_wr    = (op == 2'd1);
        bus_rd    = (op == 2'd2);
        bus_addr  = a;
        bus_wdata = d;
    endtask

    task automatic look(input string tag, input logic e_irq, input logic [7:0] e_id,
                        input logic e_fen);
        check(tag, "irq", 32'(irq), 32'(e_irq));
        check(tag, "id", 32'(iir_rdata), 32'(e_id));
        check(tag, "fifo_en", 32'(fifo_en), 32'(e_fen));
    endtask

    task automatic pulses(input string tag, input logic e_rx, input logic e_tx);
        check(tag, "rx_fifo_rst", 32'(rx_fifo_rst), 32'(e_rx));
        check(tag, "tx_fifo_rst", 32'(tx_fifo_rst), 32'(e_tx));
    endtask

    task automatic fc_write(input logic [7:0] d);
        put(2'd1, 3'd2, d);
        @(negedge clk);
        put(2'd0, 3'd0, 8'h00);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        // R1: reset state
        repeat (2) @(negedge clk);
        look("R1", 1'b0, 8'h01, 1'b0);
        pulses("R1", 1'b0, 1'b0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            put(VEC[i].op, VEC[i].addr, VEC[i].wd);
            rx_count   = VEC[i].rxc;
            tx_count   = VEC[i].txc;
            rx_timeout = VEC[i].to;
            thr_empty  = VEC[i].thre;
            msr_delta  = VEC[i].msr;
            @(negedge clk);
            look($sformatf("R%0d row%0d", VEC[i].req, i), VEC[i].e_irq, VEC[i].e_id,
                 VEC[i].e_fen);
        end
        put(2'd0, 3'd0, 8'h00);
        rx_timeout = 1'b0;
        rx_count   = '0;

        // R3: both clear bits, mode unchanged
        fc_write(8'h06);
        pulses("R3 both", 1'b1, 1'b1);
        check("R3", "fifo_en", 32'(fifo_en), 32'd0);
        @(negedge clk);
        pulses("R3 one cycle", 1'b0, 1'b0);
        fc_write(8'h02);
        pulses("R3 rx only", 1'b1, 1'b0);
        fc_write(8'h04);
        pulses("R3 tx only", 1'b0, 1'b1);
        fc_write(8'h00);
        pulses("R3 zero write", 1'b0, 1'b0);

        // R4: mode change flushes both, same mode rewrite does not
        fc_write(8'h01);
        pulses("R4 flip", 1'b1, 1'b1);
        look("R4", 1'b0, 8'hC1, 1'b1);
        fc_write(8'h01);
        pulses("R4 same mode", 1'b0, 1'b0);

        // R10: masked source stays latched
        src_en    = 3'b000;
        msr_delta = 4'h8;
        @(negedge clk);
        msr_delta = 4'h0;
        look("R10 masked", 1'b0, 8'hC1, 1'b1);
        src_en = 3'b001;
        @(negedge clk);
        look("R10 unmasked", 1'b1, 8'hC0, 1'b1);

        // R1: reset in the middle of operation
        rst = 1'b1;
        @(negedge clk);
        look("R1 mid", 1'b0, 8'h01, 1'b0);
        pulses("R1 mid", 1'b0, 1'b0);
        rst = 1'b0;
        @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule